// File: doc/BRIEF.md
# Bit-Serial Codec Command Shifter

This block turns a parallel request into a serial frame for an audio codec or for the capture-gain chips that sit beside it. On a one-cycle `start`, the block builds a frame word from one of four request kinds:
- a raw 16-bit codec command;
- a playback level command, formed by adding a level code to a per-channel base code;
- one of six fixed codec commands picked by a small index;
- a 32-bit capture-gain word that packs the microphone level twice, then the right level, then the left level.

It then plays the word out one bit per cycle, most significant bit first. The bit rides on the top lane of a byte-wide data output.

Each frame has a fixed shape:
1. An open marker.
2. The data bits.
3. A close marker.
4. A single-cycle done pulse.

Chip select stays active for the open, bit and close cycles. While a frame runs, the block reports busy and ignores new requests. A request that names a channel or a fixed-command index that does not exist produces a reject pulse and sends nothing.

Top module: `codec_cmd_shifter`

## Requirements
- R1: Request kind 0 sends `raw_cmd` as a 16-bit frame, most significant bit first.
- R2: Request kind 2 sends a 32-bit frame, most significant bit first. Bits 31:24 carry `gain_mic`, bits 23:16 carry `gain_mic` again, bits 15:8 carry `gain_right` and bits 7:0 carry `gain_left`.
- R3: During a bit cycle, `ser_byte` is 8'h80 for a 1 bit and 8'h00 for a 0 bit. In every other cycle `ser_byte` is 8'h00.
- R4: `frm_open` is high for the single cycle before the first bit. `frm_close` is high for the single cycle after the last bit. `cs_out` is low (active low) from the open cycle through the close cycle and high otherwise.
- R5: Request kind 1 sends a 16-bit frame equal to the base code plus `play_level`. The base code is 16'hA600 when `play_chan` is 0 and 16'hA700 when it is 1.
- R6: A kind 1 request with `play_chan` above 1 sends no frame. `reject` pulses for one cycle, in the cycle after the request, while `busy`, `frm_open` and `cs_out` stay idle.
- R7: Request kind 3 sends a 16-bit fixed command chosen by `preset_sel`: 0 gives 16'hA007, 1 gives 16'hA103, 2 gives 16'hA38D, 3 gives 16'hA30D, 4 gives 16'hA240 and 5 gives 16'hA24D. Values 6 and 7 are rejected as in R6.
- R8: `busy` is high from the cycle after an accepted request through the close cycle. A `start` seen while `busy` is high is ignored and does not change the frame in progress.
- R9: `done` is high for exactly one cycle, the cycle after the close cycle.
- R10: After reset, `busy`, `done`, `reject`, `frm_open`, `frm_close` and `bit_vld` are low, `ser_byte` is 0 and `cs_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| kind | input | 2 | Request kind: 0 raw, 1 playback, 2 capture gain, 3 fixed command |
| raw_cmd | input | 16 | Raw codec command word |
| play_chan | input | 2 | Playback channel: 0 left, 1 right |
| play_level | input | 8 | Playback level code |
| gain_left | input | 8 | Left capture level |
| gain_right | input | 8 | Right capture level |
| gain_mic | input | 8 | Microphone capture level |
| preset_sel | input | 3 | Fixed command index |
| ser_byte | output | 8 | Per-bit data byte, serial bit on bit 7 |
| bit_vld | output | 1 | High in each cycle that carries a frame bit |
| cs_out | output | 1 | Chip select, active low |
| frm_open | output | 1 | Open marker before the first bit |
| frm_close | output | 1 | Close marker after the last bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle pulse for an invalid request |

## Verification
The request is captured at clock edge E0. The open marker is due in the cycle after E0. Bit k of an N-bit frame is due in the cycle after edge E(k+1). The close marker follows the last bit, and done comes one cycle after the close. For an invalid request, reject is due in the cycle after E0. The bench drives every request at a falling edge and then samples one falling edge per cycle along this fixed timeline. It assembles the received bits into a word and compares that word, and each marker, in its own slot.

// File: rtl/codec_shift_pkg.sv
package codec_shift_pkg;

   localparam int CODE_W = 16;

   typedef enum logic [1:0] {
      REQ_RAW    = 2'd0,
      REQ_PLAY   = 2'd1,
      REQ_GAIN   = 2'd2,
      REQ_PRESET = 2'd3
   } req_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_SHIFT,
      ST_CLOSE,
      ST_DONE
   } seq_state_e;

   localparam logic [CODE_W-1:0] PLAY_BASE_L = 16'hA600;
   localparam logic [CODE_W-1:0] PLAY_BASE_R = 16'hA700;

   localparam int PRESET_COUNT = 6;

   function automatic logic preset_valid(input logic [2:0] sel);
      return (int'(sel) < PRESET_COUNT);
   endfunction

   function automatic logic [CODE_W-1:0] preset_code(input logic [2:0] sel);
      logic [CODE_W-1:0] c;
      case (sel)
         3'd0:    c = 16'hA007;
         3'd1:    c = 16'hA103;
         3'd2:    c = 16'hA38D;
         3'd3:    c = 16'hA30D;
         3'd4:    c = 16'hA240;
         3'd5:    c = 16'hA24D;
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/cmd_packer.sv
module cmd_packer
   import codec_shift_pkg::*;
#(
   parameter int CMD_W = 16,
   parameter int LVL_W = 8,
   parameter int FRM_W = 4 * LVL_W,
   parameter int CNT_W = $clog2(FRM_W + 1)
) (
   input  logic [1:0]       kind,
   input  logic [CMD_W-1:0] raw_cmd,
   input  logic [1:0]       play_chan,
   input  logic [LVL_W-1:0] play_level,
   input  logic [LVL_W-1:0] gain_left,
   input  logic [LVL_W-1:0] gain_right,
   input  logic [LVL_W-1:0] gain_mic,
   input  logic [2:0]       preset_sel,
   output logic [FRM_W-1:0] frame_word,
   output logic [CNT_W-1:0] frame_len,
   output logic             req_ok
);

   localparam int PAD = FRM_W - CMD_W;

   logic [CMD_W-1:0] short_cmd;
   logic [CMD_W-1:0] play_base;
   logic [FRM_W-1:0] short_ext;
   logic [FRM_W-1:0] gain_word;

   always_comb begin
      play_base = (play_chan == 2'd0) ? CMD_W'(PLAY_BASE_L) : CMD_W'(PLAY_BASE_R);
      case (req_kind_e'(kind))
         REQ_PLAY:   short_cmd = play_base + CMD_W'(play_level);
         REQ_PRESET: short_cmd = CMD_W'(preset_code(preset_sel));
         default:    short_cmd = raw_cmd;
      endcase
   end

   always_comb begin
      short_ext = '0;
      short_ext[CMD_W-1:0] = short_cmd;
   end

   assign gain_word = {gain_mic, gain_mic, gain_right, gain_left};

   always_comb begin
      case (req_kind_e'(kind))
         REQ_GAIN: begin
            frame_word = gain_word;
            frame_len  = CNT_W'(FRM_W);
            req_ok     = 1'b1;
         end
         REQ_PLAY: begin
            frame_word = short_ext << PAD;
            frame_len  = CNT_W'(CMD_W);
            req_ok     = (play_chan <= 2'd1);
         end
         REQ_PRESET: begin
            frame_word = short_ext << PAD;
            frame_len  = CNT_W'(CMD_W);
            req_ok     = preset_valid(preset_sel);
         end
         default: begin
            frame_word = short_ext << PAD;
            frame_len  = CNT_W'(CMD_W);
            req_ok     = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
   parameter int FRM_W = 32,
   parameter int CNT_W = $clog2(FRM_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [FRM_W-1:0] load_word,
   input  logic [CNT_W-1:0] load_len,
   input  logic             step,
   output logic             ser_bit,
   output logic             last_bit
);

   logic [FRM_W-1:0] sreg;
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         remain <= '0;
      end else if (load) begin
         sreg   <= load_word;
         remain <= load_len;
      end else if (step) begin
         sreg   <= {sreg[FRM_W-2:0], 1'b0};
         remain <= remain - CNT_W'(1);
      end
   end

   assign ser_bit  = sreg[FRM_W-1];
   assign last_bit = (remain == CNT_W'(1));

endmodule

// File: rtl/frame_seq.sv
module frame_seq
   import codec_shift_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic req_ok,
   input  logic last_bit,
   output logic load,
   output logic step,
   output logic open_ev,
   output logic close_ev,
   output logic done_ev,
   output logic reject_ev,
   output logic frame_act
);

   seq_state_e state, state_nx;
   logic       can_take;
   logic       reject_q;

   assign can_take = (state == ST_IDLE) || (state == ST_DONE);
   assign load     = can_take && start && req_ok;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (load) state_nx = ST_OPEN;
         ST_OPEN:  state_nx = ST_SHIFT;
         ST_SHIFT: if (last_bit) state_nx = ST_CLOSE;
         ST_CLOSE: state_nx = ST_DONE;
         ST_DONE:  state_nx = load ? ST_OPEN : ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         reject_q <= 1'b0;
      end else begin
         state    <= state_nx;
         reject_q <= can_take && start && !req_ok;
      end
   end

   assign step      = (state == ST_SHIFT);
   assign open_ev   = (state == ST_OPEN);
   assign close_ev  = (state == ST_CLOSE);
   assign done_ev   = (state == ST_DONE);
   assign reject_ev = reject_q;
   assign frame_act = (state == ST_OPEN) || (state == ST_SHIFT) || (state == ST_CLOSE);

endmodule

// File: rtl/codec_cmd_shifter.sv
module codec_cmd_shifter
   import codec_shift_pkg::*;
#(
   parameter int CMD_W     = 16,
   parameter int LVL_W     = 8,
   parameter int BYTE_W    = 8,
   parameter int DATA_LANE = 7,
   parameter bit CS_ACT_HI = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        kind,
   input  logic [CMD_W-1:0]  raw_cmd,
   input  logic [1:0]        play_chan,
   input  logic [LVL_W-1:0]  play_level,
   input  logic [LVL_W-1:0]  gain_left,
   input  logic [LVL_W-1:0]  gain_right,
   input  logic [LVL_W-1:0]  gain_mic,
   input  logic [2:0]        preset_sel,
   output logic [BYTE_W-1:0] ser_byte,
   output logic              bit_vld,
   output logic              cs_out,
   output logic              frm_open,
   output logic              frm_close,
   output logic              busy,
   output logic              done,
   output logic              reject
);

   localparam int FRM_W = 4 * LVL_W;
   localparam int CNT_W = $clog2(FRM_W + 1);

   if (CMD_W < CODE_W) begin : g_bad_cmd
      $error("CMD_W must hold the fixed codec codes");
   end
   if (FRM_W < CMD_W) begin : g_bad_frm
      $error("gain frame must be at least as wide as a command");
   end
   if (LVL_W > CMD_W) begin : g_bad_lvl
      $error("level code wider than command");
   end
   if (DATA_LANE >= BYTE_W || DATA_LANE < 0) begin : g_bad_lane
      $error("DATA_LANE outside the data byte");
   end

   logic [FRM_W-1:0] pk_word;
   logic [CNT_W-1:0] pk_len;
   logic             pk_ok;
   logic             sq_load, sq_step, sq_act;
   logic             sh_bit, sh_last;

   cmd_packer #(
      .CMD_W(CMD_W), .LVL_W(LVL_W), .FRM_W(FRM_W), .CNT_W(CNT_W)
   ) u_pack (
      .kind       (kind),
      .raw_cmd    (raw_cmd),
      .play_chan  (play_chan),
      .play_level (play_level),
      .gain_left  (gain_left),
      .gain_right (gain_right),
      .gain_mic   (gain_mic),
      .preset_sel (preset_sel),
      .frame_word (pk_word),
      .frame_len  (pk_len),
      .req_ok     (pk_ok)
   );

   frame_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .req_ok    (pk_ok),
      .last_bit  (sh_last),
      .load      (sq_load),
      .step      (sq_step),
      .open_ev   (frm_open),
      .close_ev  (frm_close),
      .done_ev   (done),
      .reject_ev (reject),
      .frame_act (sq_act)
   );

   bit_shifter #(
      .FRM_W(FRM_W), .CNT_W(CNT_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sq_load),
      .load_word (pk_word),
      .load_len  (pk_len),
      .step      (sq_step),
      .ser_bit   (sh_bit),
      .last_bit  (sh_last)
   );

   assign bit_vld = sq_step;
   assign busy    = sq_act;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
      if (b == DATA_LANE) begin : g_data
         assign ser_byte[b] = sq_step & sh_bit;
      end else begin : g_zero
         assign ser_byte[b] = 1'b0;
      end
   end

   if (CS_ACT_HI) begin : g_cs_hi
      assign cs_out = sq_act;
   end else begin : g_cs_lo
      assign cs_out = ~sq_act;
   end

endmodule

// File: rtl/codec_cmd_shifter_chk.sv
module codec_cmd_shifter_chk #(
   parameter int CMD_W     = 16,
   parameter int FRM_W     = 32,
   parameter int BYTE_W    = 8,
   parameter bit CS_ACT_HI = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [BYTE_W-1:0] ser_byte,
   input logic              bit_vld,
   input logic              cs_out,
   input logic              frm_open,
   input logic              frm_close,
   input logic              busy,
   input logic              done,
   input logic              reject
);

   logic [7:0] run_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_bits <= '0;
      else if (frm_open) run_bits <= '0;
      else if (bit_vld)  run_bits <= run_bits + 8'd1;
   end

   AST_IDLE_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |-> (ser_byte == '0)); // R3
   AST_OPEN_LEADS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      frm_open |=> bit_vld); // R4
   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_open || bit_vld || frm_close) |-> (cs_out == CS_ACT_HI)); // R4
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      frm_close |-> (run_bits == 8'(CMD_W) || run_bits == 8'(FRM_W))); // R1
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> (!busy && !frm_open)); // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && start) |=> !frm_open); // R8
   AST_CLOSE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_close |=> (done && !busy)); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

endmodule

bind codec_cmd_shifter codec_cmd_shifter_chk #(
   .CMD_W(CMD_W), .FRM_W(4 * LVL_W), .BYTE_W(BYTE_W), .CS_ACT_HI(CS_ACT_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .ser_byte(ser_byte),
   .bit_vld(bit_vld), .cs_out(cs_out), .frm_open(frm_open),
   .frm_close(frm_close), .busy(busy), .done(done), .reject(reject)
);

// File: tb/sim_codec_cmd_shifter.sv
module sim_codec_cmd_shifter;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] kind = '0;
   logic [15:0] raw_cmd = '0;
   logic [1:0] play_chan = '0;
   logic [7:0] play_level = '0;
   logic [7:0] gain_left = '0, gain_right = '0, gain_mic = '0;
   logic [2:0] preset_sel = '0;
   logic [7:0] ser_byte;
   logic       bit_vld, cs_out, frm_open, frm_close, busy, done, reject;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   codec_cmd_shifter u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .raw_cmd(raw_cmd),
      .play_chan(play_chan), .play_level(play_level), .gain_left(gain_left),
      .gain_right(gain_right), .gain_mic(gain_mic), .preset_sel(preset_sel),
      .ser_byte(ser_byte), .bit_vld(bit_vld), .cs_out(cs_out),
      .frm_open(frm_open), .frm_close(frm_close), .busy(busy), .done(done),
      .reject(reject)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_preset(input logic [2:0] s);
      case (s)
         3'd0: return 16'hA007;
         3'd1: return 16'hA103;
         3'd2: return 16'hA38D;
         3'd3: return 16'hA30D;
         3'd4: return 16'hA240;
         3'd5: return 16'hA24D;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic bit exp_ok();
      if (kind == 2'd1) return play_chan <= 2'd1;
      if (kind == 2'd3) return preset_sel <= 3'd5;
      return 1'b1;
   endfunction

   function automatic int exp_len();
      return (kind == 2'd2) ? 32 : 16;
   endfunction

   function automatic logic [31:0] exp_word();
      case (kind)
         2'd0: return {16'h0, raw_cmd};
         2'd1: return {16'h0, ((play_chan == 2'd0) ? 16'hA600 : 16'hA700) + {8'h0, play_level}};
         2'd2: return {gain_mic, gain_mic, gain_right, gain_left};
         default: return {16'h0, exp_preset(preset_sel)};
      endcase
   endfunction

   function automatic string req_tag();
      case (kind)
         2'd0: return "R1";
         2'd1: return "R5";
         2'd2: return "R2";
         default: return "R7";
      endcase
   endfunction

   // Drive one request at a falling edge and follow its timeline.
   task automatic run_req(input bit poke_busy);
      logic [31:0] got;
      logic [31:0] want;
      int          len;
      bit          ok;
      ok   = exp_ok();
      len  = exp_len();
      want = exp_word();
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (!ok) begin
         check("R6 reject pulse", 32'(reject), 32'd1);
         check("R6 no busy", 32'(busy), 32'd0);
         check("R6 no open", 32'(frm_open), 32'd0);
         check("R6 cs idle", 32'(cs_out), 32'd1);
         @(negedge clk);
         check("R6 reject single", 32'(reject), 32'd0);
         check("R6 still idle", 32'(busy), 32'd0);
         return;
      end
      check("R4 open marker", 32'(frm_open), 32'd1);
      check("R4 cs active at open", 32'(cs_out), 32'd0);
      check("R8 busy at open", 32'(busy), 32'd1);
      got = '0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         start = 1'b0;
         check("R3 bit valid", 32'(bit_vld), 32'd1);
         check("R3 lane only", 32'(ser_byte & 8'h7F), 32'd0);
         check("R4 cs held", 32'(cs_out), 32'd0);
         got = {got[30:0], ser_byte[7]};
         if (poke_busy && k == 3) begin
            // R8: request during a frame, with different contents
            kind = 2'd2;
            start = 1'b1;
         end
      end
      @(negedge clk);
      start = 1'b0;
      check({req_tag(), " frame word"}, got, want);
      check("R4 close marker", 32'(frm_close), 32'd1);
      check("R3 byte zero at close", 32'(ser_byte), 32'd0);
      check("R8 busy at close", 32'(busy), 32'd1);
      @(negedge clk);
      check("R9 done pulse", 32'(done), 32'd1);
      check("R8 busy low at done", 32'(busy), 32'd0);
      check("R4 cs released", 32'(cs_out), 32'd1);
      @(negedge clk);
      check("R9 done single", 32'(done), 32'd0);
      check("R8 no restart", 32'(frm_open), 32'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 busy", 32'(busy), 32'd0);
      check("R10 done", 32'(done), 32'd0);
      check("R10 reject", 32'(reject), 32'd0);
      check("R10 byte", 32'(ser_byte), 32'd0);
      check("R10 cs", 32'(cs_out), 32'd1);
      check("R10 bit_vld", 32'(bit_vld), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      kind = 2'd0; raw_cmd = 16'h8001; run_req(1'b0);              // R1
      kind = 2'd0; raw_cmd = 16'hFFFF; run_req(1'b0);              // R1
      kind = 2'd1; play_chan = 2'd0; play_level = 8'hFF; run_req(1'b0); // R5
      kind = 2'd1; play_chan = 2'd1; play_level = 8'h00; run_req(1'b0); // R5
      kind = 2'd1; play_chan = 2'd2; run_req(1'b0);                // R6
      kind = 2'd1; play_chan = 2'd3; run_req(1'b0);                // R6
      for (int s = 0; s < 8; s++) begin
         kind = 2'd3; preset_sel = 3'(s); run_req(1'b0);           // R7
      end
      kind = 2'd2; gain_mic = 8'hC3; gain_right = 8'h5A; gain_left = 8'h01;
      run_req(1'b0);                                               // R2
      kind = 2'd0; raw_cmd = 16'h1234; run_req(1'b1);              // R8

      // random mix
      for (int i = 0; i < 48; i++) begin
         kind       = 2'($urandom_range(0, 3));
         raw_cmd    = 16'($urandom);
         play_chan  = 2'($urandom_range(0, 3));
         play_level = 8'($urandom);
         gain_left  = 8'($urandom);
         gain_right = 8'($urandom);
         gain_mic   = 8'($urandom);
         preset_sel = 3'($urandom_range(0, 7));
         run_req(i % 7 == 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule